// File: doc/BRIEF.md
# Bidirectional Interval Timer with Match Comparators

This block is a free-standing timer counter for a peripheral subsystem. Its counter advances by one on each prescaler tick and can run up or down. In interval mode the count is confined to the range 0 to interval-1. In free-running mode it uses the whole counter width. Whenever the count leaves its range, in either direction, it is folded back and a wrap event is raised. The wrap is reported as an interval event or as an overflow event, depending on the selected mode.

Three match comparators watch the count, and each one has its own status bit. Status bits are collected in a register that clears when it is read. They are gated with per-bit enables to drive a single active-high interrupt. Software reaches everything through a plain single-cycle register port: a write strobe, a read strobe, a 3-bit address, and a combinational read-data bus.

Top module: `wrap_timer`

## Requirements
- R1: After reset, the count (address 7) reads 0, the status (address 6) reads 0, `irq` is low, and the control word (address 0) reads 0x1, meaning halted.
- R2: With control bit 1 set (interval mode), counting up (control bit 2 clear) and interval register (address 1) value I > 0, a step from any count >= I-1 gives 0 and sets status bit 0. An interval of 0 behaves as the full 2^CW range.
- R3: In interval mode, counting down (control bit 2 set), a step from count 0 or from any count >= I gives I-1 and sets status bit 0.
- R4: With control bit 1 clear (free-running), the range is 2^CW. An up step from all-ones gives 0, and a down step from 0 gives all-ones. Either one sets status bit 4 and leaves bit 0 clear.
- R5: Match values sit at addresses 2, 3 and 4. A step whose new count equals match value k sets status bit k+1.
- R6: Writing control bit 3 loads the count with 0 when the written direction is up. When it is down, it loads I-1, or all-ones if free-running. It also restarts the prescaler. The bit always reads back 0.
- R7: Control bit 0 (halt) stops the count. Status bits already set stay unchanged while halted.
- R8: Control bits [15:8] hold a divider D: the count steps once every D+1 clock cycles. The first step comes D+1 cycles after a restart write.
- R9: Reading address 6 returns the status and clears it on that clock edge. An event raised on the same edge is still recorded.
- R10: `irq` is the OR over status bits 4..0 of status AND the enable register (address 5, bits 4..0).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (needed for read-to-clear) |
| addr | input | 3 | Register address |
| wr_data | input | CW | Write data |
| rd_data | output | CW | Read data for `addr`, combinational |
| irq | output | 1 | Active-high interrupt |

## Verification
The range assertion assumes the interval register is not rewritten on the same edge as a step. The bench therefore writes the interval only while the counter is halted. It then reaches out-of-range counts deliberately, by halting, shrinking the interval and stepping once. The match and clear assertions take status reads to be single-cycle strobes, which is how the bench drives every read. Direction and mode changes without a restart are made only while halted, so the bench controls exactly how many steps occur.

// File: rtl/wt_pkg.sv
package wt_pkg;
  localparam int REG_AW  = 3;
  localparam int MATCH_N = 3;
  localparam int ST_W    = MATCH_N + 2;
  localparam int ST_IVL  = 0;
  localparam int ST_MT0  = 1;
  localparam int ST_OVF  = MATCH_N + 1;

  localparam int CB_HALT    = 0;
  localparam int CB_IVL     = 1;
  localparam int CB_DOWN    = 2;
  localparam int CB_RESTART = 3;
  localparam int CB_DIV_LO  = 8;

  typedef enum logic [REG_AW-1:0] {
    A_CTRL = 3'd0,
    A_IVAL = 3'd1,
    A_MT0  = 3'd2,
    A_MT1  = 3'd3,
    A_MT2  = 3'd4,
    A_IEN  = 3'd5,
    A_STS  = 3'd6,
    A_CNT  = 3'd7
  } reg_addr_e;
endpackage

// File: rtl/wt_prescaler.sv
module wt_prescaler #(
  parameter int PW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          restart,
  input  logic [PW-1:0] div,
  output logic          tick
);
  localparam logic [PW-1:0] P_ONE = PW'(1);

  logic [PW-1:0] pc;

  assign tick = run && (pc == div);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pc <= '0;
    else if (restart) pc <= '0;
    else if (run)     pc <= (pc == div) ? '0 : pc + P_ONE;
  end
endmodule

// File: rtl/wt_count_core.sv
module wt_count_core #(
  parameter int CW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv,
  input  logic          restart,
  input  logic          ld_down,
  input  logic          ld_ivl,
  input  logic          down,
  input  logic          ivl,
  input  logic [CW-1:0] interval,
  output logic [CW-1:0] cnt,
  output logic [CW-1:0] cnt_nxt,
  output logic          step,
  output logic          wrap
);
  localparam logic [CW-1:0] ONE = CW'(1);

  // Highest legal count: interval-1 in interval mode, all-ones otherwise.
  function automatic logic [CW-1:0] top_value(input logic ivl_on,
                                              input logic [CW-1:0] iv);
    if (ivl_on && (iv != '0)) return iv - ONE;
    return '1;
  endfunction

  // One step with fold-back; MSB of result flags the wrap.
  function automatic logic [CW:0] advance(input logic [CW-1:0] cur,
                                          input logic [CW-1:0] top,
                                          input logic          dn);
    if (!dn)
      return (cur >= top) ? {1'b1, {CW{1'b0}}} : {1'b0, cur + ONE};
    return ((cur == '0) || (cur > top)) ? {1'b1, top} : {1'b0, cur - ONE};
  endfunction

  logic [CW-1:0] run_top, ld_top;
  logic          wrap_c;

  always_comb begin
    run_top           = top_value(ivl, interval);
    ld_top            = top_value(ld_ivl, interval);
    {wrap_c, cnt_nxt} = advance(cnt, run_top, down);
  end

  assign step = adv && !restart;
  assign wrap = step && wrap_c;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= '0;
    else if (restart) cnt <= ld_down ? ld_top : '0;
    else if (step)    cnt <= cnt_nxt;
  end
endmodule

// File: rtl/wt_match_bank.sv
module wt_match_bank #(
  parameter int CW = 32,
  parameter int NM = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NM-1:0]          wr_sel,
  input  logic [CW-1:0]          wr_data,
  input  logic                   step,
  input  logic [CW-1:0]          cnt_nxt,
  output logic [NM-1:0][CW-1:0]  mval,
  output logic [NM-1:0]          hit
);
  for (genvar k = 0; k < NM; k++) begin : g_cmp
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         mval[k] <= '0;
      else if (wr_sel[k]) mval[k] <= wr_data;
    end
    assign hit[k] = step && (cnt_nxt == mval[k]);
  end
endmodule

// File: rtl/wrap_timer.sv
module wrap_timer
  import wt_pkg::*;
#(
  parameter int CW = 32,
  parameter int PW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [REG_AW-1:0] addr,
  input  logic [CW-1:0]     wr_data,
  output logic [CW-1:0]     rd_data,
  output logic              irq
);
  localparam int DIV_HI = CB_DIV_LO + PW - 1;

  logic          halt_q, ivl_q, down_q;
  logic [PW-1:0] div_q;
  logic [CW-1:0] interval_q;
  logic [ST_W-1:0] ien_q, sts_q;

  logic ctrl_wr, restart_w, ld_down_w, ld_ivl_w, sts_clr_w;
  logic tick_w, step_w, wrap_w;
  logic [CW-1:0] cnt_w, cnt_nxt_w;
  logic [MATCH_N-1:0] hit_w, msel_w;
  logic [MATCH_N-1:0][CW-1:0] mval_w;
  logic [ST_W-1:0] evt_w;
  logic [CW-1:0] ctrl_rd;
  logic unused_bits;

  assign ctrl_wr   = wr_en && (addr == A_CTRL);
  assign restart_w = ctrl_wr && wr_data[CB_RESTART];
  assign ld_down_w = wr_data[CB_DOWN];
  assign ld_ivl_w  = wr_data[CB_IVL];
  assign sts_clr_w = rd_en && (addr == A_STS);
  assign unused_bits = ^{wr_data[CB_DIV_LO-1:CB_RESTART+1], wr_data[CW-1:DIV_HI+1]};

  for (genvar k = 0; k < MATCH_N; k++) begin : g_msel
    assign msel_w[k] = wr_en && (addr == REG_AW'(int'(A_MT0) + k));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      halt_q     <= 1'b1;
      ivl_q      <= 1'b0;
      down_q     <= 1'b0;
      div_q      <= '0;
      interval_q <= '0;
      ien_q      <= '0;
    end else if (wr_en) begin
      case (addr)
        A_CTRL: begin
          halt_q <= wr_data[CB_HALT];
          ivl_q  <= wr_data[CB_IVL];
          down_q <= wr_data[CB_DOWN];
          div_q  <= wr_data[DIV_HI:CB_DIV_LO];
        end
        A_IVAL:  interval_q <= wr_data;
        A_IEN:   ien_q      <= wr_data[ST_W-1:0];
        default: ;
      endcase
    end
  end

  wt_prescaler #(.PW(PW)) u_presc (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (!halt_q),
    .restart (restart_w),
    .div     (div_q),
    .tick    (tick_w)
  );

  wt_count_core #(.CW(CW)) u_core (
    .clk      (clk),
    .rst_n    (rst_n),
    .adv      (tick_w),
    .restart  (restart_w),
    .ld_down  (ld_down_w),
    .ld_ivl   (ld_ivl_w),
    .down     (down_q),
    .ivl      (ivl_q),
    .interval (interval_q),
    .cnt      (cnt_w),
    .cnt_nxt  (cnt_nxt_w),
    .step     (step_w),
    .wrap     (wrap_w)
  );

  wt_match_bank #(.CW(CW), .NM(MATCH_N)) u_match (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_sel  (msel_w),
    .wr_data (wr_data),
    .step    (step_w),
    .cnt_nxt (cnt_nxt_w),
    .mval    (mval_w),
    .hit     (hit_w)
  );

  // Wrap kind follows the mode: interval event or overflow event.
  assign evt_w = {wrap_w && !ivl_q, hit_w, wrap_w && ivl_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sts_q <= '0;
    else        sts_q <= (sts_clr_w ? '0 : sts_q) | evt_w;
  end

  assign irq = |(sts_q & ien_q);

  always_comb begin
    ctrl_rd                   = '0;
    ctrl_rd[CB_HALT]          = halt_q;
    ctrl_rd[CB_IVL]           = ivl_q;
    ctrl_rd[CB_DOWN]          = down_q;
    ctrl_rd[DIV_HI:CB_DIV_LO] = div_q;
  end

  always_comb begin
    case (addr)
      A_CTRL:  rd_data = ctrl_rd;
      A_IVAL:  rd_data = interval_q;
      A_MT0:   rd_data = mval_w[0];
      A_MT1:   rd_data = mval_w[1];
      A_MT2:   rd_data = mval_w[2];
      A_IEN:   rd_data = CW'(ien_q);
      A_STS:   rd_data = CW'(sts_q);
      default: rd_data = cnt_w;
    endcase
  end
endmodule

// File: rtl/wt_checker.sv
module wt_checker #(
  parameter int CW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          step,
  input logic          wrap,
  input logic          ivl,
  input logic          halt,
  input logic          restart,
  input logic          ld_down,
  input logic          sts_clr,
  input logic [CW-1:0] interval,
  input logic [CW-1:0] cnt,
  input logic [2:0]    hit,
  input logic [4:0]    sts
);
  // R2
  in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && ivl && (interval != '0)) |=> (cnt < $past(interval)));

  // R2
  ivl_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap && ivl) |=> sts[0]);

  // R4
  ovf_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap && !ivl) |=> sts[4]);

  // R5
  match_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|hit) |=> ((sts[3:1] & $past(hit)) == $past(hit)));

  // R6
  restart_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (restart && !ld_down) |=> (cnt == '0));

  // R7
  halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (halt && !restart) |=> $stable(cnt));

  // R9
  read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_clr && (hit == '0) && !wrap) |=> (sts == '0));
endmodule

bind wrap_timer wt_checker #(.CW(CW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .step     (step_w),
  .wrap     (wrap_w),
  .ivl      (ivl_q),
  .halt     (halt_q),
  .restart  (restart_w),
  .ld_down  (ld_down_w),
  .sts_clr  (sts_clr_w),
  .interval (interval_q),
  .cnt      (cnt_w),
  .hit      (hit_w),
  .sts      (sts_q)
);

// File: tb/tb_wrap_timer.sv
module tb_wrap_timer;
  import wt_pkg::*;

  localparam int CW = 32;
  localparam logic [CW-1:0] C_HALT = 32'h1;
  localparam logic [CW-1:0] C_IVL  = 32'h2;
  localparam logic [CW-1:0] C_DOWN = 32'h4;
  localparam logic [CW-1:0] C_RST  = 32'h8;

  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [2:0] addr = '0;
  logic [CW-1:0] wr_data = '0;
  logic [CW-1:0] rd_data;
  logic irq;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  wrap_timer #(.CW(CW), .PW(8)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wr_data(wr_data), .rd_data(rd_data), .irq(irq)
  );

  // ctrl, interval, steps, expected count, expected status
  typedef struct packed {
    logic [31:0] ctrl;
    logic [31:0] ival;
    logic [31:0] n;
    logic [31:0] cnt;
    logic [31:0] sts;
  } vec_t;

  localparam vec_t VT [9] = '{
    '{32'h2, 32'd5, 32'd3, 32'd3,          32'h02},
    '{32'h2, 32'd5, 32'd5, 32'd0,          32'h03},
    '{32'h2, 32'd5, 32'd7, 32'd2,          32'h03},
    '{32'h6, 32'd5, 32'd1, 32'd3,          32'h02},
    '{32'h6, 32'd5, 32'd5, 32'd4,          32'h03},
    '{32'h0, 32'd5, 32'd7, 32'd7,          32'h06},
    '{32'h4, 32'd5, 32'd3, 32'hFFFF_FFFC,  32'h08},
    '{32'h6, 32'd8, 32'd9, 32'd6,          32'h07},
    '{32'h2, 32'd0, 32'd4, 32'd4,          32'h02}
  };

  task automatic check(input string tag, input logic [CW-1:0] got,
                       input logic [CW-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, got, exp);
    end
  endtask

  // All tasks start and end at a falling edge; each access uses one rising edge.
  task automatic wr(input logic [2:0] a, input logic [CW-1:0] d);
    wr_en = 1'b1; addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [CW-1:0] v);
    rd_en = 1'b1; addr = a;
    #1 v = rd_data;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Restart, then take exactly n steps (n >= 1) and halt.
  task automatic run_steps(input logic [CW-1:0] ctrl, input int n);
    wr(A_CTRL, ctrl | C_RST);
    idle(n - 1);
    wr(A_CTRL, ctrl | C_HALT);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    logic [CW-1:0] v;
    string tag;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 irq", CW'(irq), '0);
    rd(A_CNT, v);  check("R1 count", v, '0);
    rd(A_STS, v);  check("R1 status", v, '0);
    rd(A_CTRL, v); check("R1 control", v, 32'h1);

    wr(A_MT0, 32'd3);
    wr(A_MT1, 32'd6);
    wr(A_MT2, 32'hFFFF_FFFD);

    // Table walk: R2 R3 R4 R5 R6
    for (int i = 0; i < 9; i++) begin
      if (VT[i].ctrl[1] && VT[i].ctrl[2]) tag = "R3,R5";
      else if (VT[i].ctrl[1])            tag = "R2,R5";
      else                                tag = "R4,R5";
      wr(A_IVAL, VT[i].ival);
      run_steps(VT[i].ctrl, int'(VT[i].n));
      rd(A_CNT, v); check($sformatf("%s vec%0d count", tag, i), v, VT[i].cnt);
      rd(A_STS, v); check($sformatf("%s vec%0d status", tag, i), v, VT[i].sts);
    end

    // R4 up overflow; R6 down restart loads all-ones in free mode
    wr(A_CTRL, C_DOWN | C_HALT | C_RST);
    rd(A_CNT, v);  check("R6 down restart", v, 32'hFFFF_FFFF);
    rd(A_CTRL, v); check("R6 restart reads 0", v, 32'h5);
    wr(A_CTRL, 32'h0);
    wr(A_CTRL, C_HALT);
    rd(A_CNT, v); check("R4 up rollover count", v, '0);
    rd(A_STS, v); check("R4 up rollover status", v, 32'h10);

    // R4 down overflow
    wr(A_CTRL, C_HALT | C_RST);
    wr(A_CTRL, C_DOWN);
    wr(A_CTRL, C_DOWN | C_HALT);
    rd(A_CNT, v); check("R4 down rollover count", v, 32'hFFFF_FFFF);
    rd(A_STS, v); check("R4 down rollover status", v, 32'h10);

    // R3 fold from above interval when counting down
    run_steps(32'h0, 7);
    rd(A_STS, v); check("R5 free match status", v, 32'h06);
    wr(A_IVAL, 32'd5);
    wr(A_CTRL, C_IVL | C_DOWN);
    wr(A_CTRL, C_IVL | C_DOWN | C_HALT);
    rd(A_CNT, v); check("R3 fold count", v, 32'd4);
    rd(A_STS, v); check("R3 fold status", v, 32'h01);

    // R2 fold from above interval when counting up
    run_steps(32'h0, 7);
    rd(A_STS, v);
    wr(A_CTRL, C_IVL);
    wr(A_CTRL, C_IVL | C_HALT);
    rd(A_CNT, v); check("R2 fold count", v, 32'd0);
    rd(A_STS, v); check("R2 fold status", v, 32'h01);

    // R7 halt keeps count and status
    run_steps(32'h0, 3);
    idle(20);
    rd(A_CNT, v); check("R7 halted count", v, 32'd3);
    rd(A_STS, v); check("R7 halted status", v, 32'h02);

    // R10 interrupt gating
    wr(A_IEN, 32'h02);
    run_steps(32'h0, 3);
    check("R10 enabled irq", CW'(irq), 32'h1);
    wr(A_IEN, 32'h01);
    check("R10 masked irq", CW'(irq), 32'h0);
    wr(A_IEN, 32'h02);
    rd(A_STS, v); check("R9 read value", v, 32'h02);
    check("R9 R10 irq after clear", CW'(irq), 32'h0);
    wr(A_IEN, 32'h0);

    // R8 prescaler: divider 3 -> one step per 4 cycles
    wr(A_CTRL, 32'h300 | C_RST);
    idle(7);
    rd(A_CNT, v); check("R8 first step", v, 32'd1);
    rd(A_CNT, v); check("R8 second step", v, 32'd2);
    wr(A_CTRL, C_HALT);

    // R9 event on the clearing edge is kept
    wr(A_CTRL, C_RST);
    rd(A_STS, v);
    rd(A_STS, v);
    rd(A_STS, v);
    wr(A_CTRL, C_HALT);
    rd(A_STS, v); check("R9 collision status", v, 32'h02);
    rd(A_CNT, v); check("R9 collision count", v, 32'd4);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule